// File: doc/BRIEF.md
# Coherence-to-Memory Request Bridge

This block lives in the memory-controller tile. It converts coherence traffic into requests on a plain valid/available main-memory port. Two input queues feed it. The forwarded-request queue carries shared and modified fetches, which become memory reads. The response queue carries writebacks, which become memory writes with a per-byte dirty mask. A two-way round-robin grant decides which queue is served.

Memory read responses are queued in a small buffer. They leave as data packets, tagged with the response address, whenever the response network can take them. When the build-time swap option is on, the bytes inside every 32-bit word of a line are reversed. This applies both to write data heading to memory and to read data coming back.

Only one memory read may be outstanding at a time. While a read waits for its data, the bridge issues neither reads nor writes.

Top module: `coh_mem_bridge`

## Requirements
- R1: After reset, `mem_rd_o`, `mem_wr_o`, `fwd_pop_o`, `wb_pop_o` and `out_valid_o` are low and `mem_avail_o` is high.
- R2: A memory read is issued when all of these hold in the same cycle:
  - the forwarded queue is granted;
  - its kind is 0 (shared fetch) or 1 (modified fetch);
  - `enable_i` is high, no read is outstanding and `mem_rd_avail_i` is high.
  In that cycle `mem_rd_o` and `fwd_pop_o` are high, `mem_addr_o` equals `fwd_addr_i`, and `mem_instr_o` follows `fwd_instr_i`. With `mem_rd_avail_i` low the head is neither issued nor popped.
- R3: From the cycle after a read is issued, no read or write is issued until a memory response arrives whose address equals the read address. A response with any other address leaves the block stalled.
- R4: A memory write is issued when all of these hold in the same cycle:
  - the response queue is granted;
  - its kind is 2 (writeback);
  - `mem_wr_avail_i` and `net_avail_i` are high;
  - the read-response buffer is empty.
  In that cycle `mem_wr_o` and `wb_pop_o` are high, and `mem_addr_o` and `mem_mask_o` equal the writeback's address and mask.
- R5: With `enable_i` low, no request is issued and neither queue is popped.
- R6: A forwarded packet of kind 2 or 3, or a response-queue packet of kind 0, 1 or 3, is popped when granted and produces no memory request.
- R7: Round-robin grant:
  - After reset the forwarded queue has priority.
  - When both queues hold packets, each pop hands priority to the other queue.
  - A granted head that cannot proceed keeps the grant.
- R8: Every memory response is buffered, up to `RSP_DEPTH` entries, and presented in arrival order on `out_valid_o`/`out_addr_o`/`out_data_o`. An entry is removed in a cycle with `net_avail_i` high. `mem_avail_o` is low while the buffer is full.
- R9: Byte order:
  - With `SWAP_EN`=1, byte k of every 32-bit word is exchanged with byte 3-k. This applies to `mem_data_o` on writes and to `out_data_o`.
  - With `SWAP_EN`=0, both carry the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows requests to be issued |
| fwd_valid_i | input | 1 | Forwarded-request queue has a head |
| fwd_kind_i | input | 2 | Head kind: 0 shared fetch, 1 modified fetch, 2 writeback, 3 other |
| fwd_addr_i | input | ADDR_W | Line address of the forwarded head |
| fwd_instr_i | input | 1 | Forwarded head is an instruction fetch |
| fwd_pop_o | output | 1 | Forwarded head consumed |
| wb_valid_i | input | 1 | Response queue has a head |
| wb_kind_i | input | 2 | Head kind, same encoding as `fwd_kind_i` |
| wb_addr_i | input | ADDR_W | Writeback line address |
| wb_data_i | input | DATA_W | Writeback line data |
| wb_mask_i | input | DATA_W/8 | Dirty byte mask, one bit per byte |
| wb_pop_o | output | 1 | Response head consumed |
| mem_addr_o | output | ADDR_W | Memory request address |
| mem_mask_o | output | DATA_W/8 | Memory write byte enables |
| mem_data_o | output | DATA_W | Memory write data |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_instr_o | output | 1 | Read is an instruction fetch |
| mem_avail_o | output | 1 | Bridge can accept a memory response |
| mem_rd_avail_i | input | 1 | Memory accepts a read |
| mem_wr_avail_i | input | 1 | Memory accepts a write |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_addr_i | input | ADDR_W | Memory response address |
| mem_rsp_data_i | input | DATA_W | Memory response data |
| net_avail_i | input | 1 | Response network can take a packet |
| out_valid_o | output | 1 | Data packet available |
| out_addr_o | output | ADDR_W | Data packet address |
| out_data_o | output | DATA_W | Data packet line |

## Verification
Reads are driven from both fetch kinds, alongside a pending writeback. This shows whether the outstanding-read stall covers writes as well as reads.

Responses are sent with a foreign address and then with the matching one. This separates "any response clears the stall" from the required address match.

Writebacks are held off by memory write availability, by network availability and by a non-empty response buffer, one cause at a time, so that each guard is exposed on its own.

A second instance built without swapping receives the same stimulus. Comparing the two shows whether the byte reversal is applied per 32-bit word on both data paths.

// File: rtl/coh_mem_pkg.sv
package coh_mem_pkg;
  typedef enum logic [1:0] {
    PKT_GETS  = 2'd0,
    PKT_GETM  = 2'd1,
    PKT_WB    = 2'd2,
    PKT_OTHER = 2'd3
  } pkt_kind_e;
endpackage

// File: rtl/cmb_rr2.sv
module cmb_rr2 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,     // [1] forwarded, [0] response
  input  logic       advance_i,
  output logic [1:0] gnt_o
);
  logic prio_fwd_q;

  always_comb begin
    if (req_i == 2'b11) gnt_o = prio_fwd_q ? 2'b10 : 2'b01;
    else                gnt_o = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prio_fwd_q <= 1'b1;
    else if (advance_i) prio_fwd_q <= gnt_o[0];
  end

  a_r7_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r7_fwd_then_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && gnt_o == 2'b10) |=> (req_i != 2'b11 || gnt_o == 2'b01));
  a_r7_wb_then_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && gnt_o == 2'b01) |=> (req_i != 2'b11 || gnt_o == 2'b10));
endmodule

// File: rtl/cmb_swap.sv
module cmb_swap #(
  parameter int DATA_W  = 512,
  parameter bit SWAP_EN = 1'b1
) (
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  localparam int WORDS = DATA_W / 32;

  if (SWAP_EN) begin : g_swap
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < 4; b++) begin : g_byte
        assign d_o[w*32 + b*8 +: 8] = d_i[w*32 + (3-b)*8 +: 8];
      end
    end
  end else begin : g_pass
    assign d_o = d_i;
  end
endmodule

// File: rtl/cmb_rsp_fifo.sv
module cmb_rsp_fifo #(
  parameter int W     = 544,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/coh_mem_bridge.sv
module coh_mem_bridge
  import coh_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 512,
  parameter int RSP_DEPTH = 4,
  parameter bit SWAP_EN   = 1'b1,
  localparam int MASK_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              fwd_valid_i,
  input  logic [1:0]        fwd_kind_i,
  input  logic [ADDR_W-1:0] fwd_addr_i,
  input  logic              fwd_instr_i,
  output logic              fwd_pop_o,
  input  logic              wb_valid_i,
  input  logic [1:0]        wb_kind_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic [MASK_W-1:0] wb_mask_i,
  output logic              wb_pop_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [MASK_W-1:0] mem_mask_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_instr_o,
  output logic              mem_avail_o,
  input  logic              mem_rd_avail_i,
  input  logic              mem_wr_avail_i,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_addr_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic              net_avail_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int ENTRY_W = ADDR_W + DATA_W;

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [1:0]        req, gnt;
  logic              fwd_is_mem, wb_is_mem;
  logic              issue_rd, issue_wr, drop_fwd, drop_wb;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic [DATA_W-1:0] wr_swapped, rsp_swapped;
  logic [ENTRY_W-1:0] fifo_dout;

  assign req = (enable_i && !pend_q) ? {fwd_valid_i, wb_valid_i} : 2'b00;

  cmb_rr2 u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .advance_i (fwd_pop_o | wb_pop_o),
    .gnt_o     (gnt)
  );

  assign fwd_is_mem = (fwd_kind_i == PKT_GETS) || (fwd_kind_i == PKT_GETM);
  assign wb_is_mem  = (wb_kind_i == PKT_WB);

  assign issue_rd = gnt[1] & fwd_is_mem & mem_rd_avail_i;
  assign drop_fwd = gnt[1] & ~fwd_is_mem;
  assign issue_wr = gnt[0] & wb_is_mem & mem_wr_avail_i & net_avail_i & fifo_empty;
  assign drop_wb  = gnt[0] & ~wb_is_mem;

  assign fwd_pop_o   = issue_rd | drop_fwd;
  assign wb_pop_o    = issue_wr | drop_wb;
  assign mem_rd_o    = issue_rd;
  assign mem_wr_o    = issue_wr;
  assign mem_instr_o = issue_rd & fwd_instr_i;
  assign mem_addr_o  = gnt[0] ? wb_addr_i : fwd_addr_i;
  assign mem_mask_o  = issue_wr ? wb_mask_i : '0;
  assign mem_data_o  = issue_wr ? wr_swapped : '0;

  cmb_swap #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_swap_wr (
    .d_i (wb_data_i),
    .d_o (wr_swapped)
  );

  cmb_swap #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_swap_rsp (
    .d_i (mem_rsp_data_i),
    .d_o (rsp_swapped)
  );

  // single outstanding read; cleared only by a response at its address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (issue_rd) begin
      pend_q      <= 1'b1;
      pend_addr_q <= fwd_addr_i;
    end else if (pend_q && mem_rsp_valid_i && mem_rsp_addr_i == pend_addr_q) begin
      pend_q      <= 1'b0;
    end
  end

  assign fifo_pop = ~fifo_empty & net_avail_i;

  cmb_rsp_fifo #(.W(ENTRY_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (mem_rsp_valid_i),
    .din_i   ({mem_rsp_addr_i, rsp_swapped}),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign mem_avail_o = ~fifo_full;
  assign out_valid_o = ~fifo_empty;
  assign out_addr_o  = fifo_dout[ENTRY_W-1 -: ADDR_W];
  assign out_data_o  = fifo_dout[DATA_W-1:0];

  a_r3_quiet_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (!mem_rd_o && !mem_wr_o));
  a_r3_read_blocks_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (!mem_rd_o && !mem_wr_o));
  a_r4_write_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_wr_avail_i && net_avail_i && !out_valid_o));
  a_r5_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (!fwd_pop_o && !wb_pop_o));
  a_r2_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  a_r2_read_needs_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_rd_avail_i && fwd_valid_i));
endmodule

// File: tb/tb_coh_mem_bridge.sv
module tb_coh_mem_bridge;
  localparam int AW = 32;
  localparam int DW = 512;
  localparam int MW = DW / 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          enable_i, fwd_valid_i, fwd_instr_i, wb_valid_i;
  logic [1:0]    fwd_kind_i, wb_kind_i;
  logic [AW-1:0] fwd_addr_i, wb_addr_i, mem_rsp_addr_i;
  logic [DW-1:0] wb_data_i, mem_rsp_data_i;
  logic [MW-1:0] wb_mask_i;
  logic          mem_rd_avail_i, mem_wr_avail_i, mem_rsp_valid_i, net_avail_i;

  logic          fwd_pop_o, wb_pop_o, mem_rd_o, mem_wr_o, mem_instr_o, mem_avail_o, out_valid_o;
  logic [AW-1:0] mem_addr_o, out_addr_o;
  logic [MW-1:0] mem_mask_o;
  logic [DW-1:0] mem_data_o, out_data_o;

  logic          p_fwd_pop, p_wb_pop, p_rd, p_wr, p_instr, p_avail, p_out_valid;
  logic [AW-1:0] p_addr, p_out_addr;
  logic [MW-1:0] p_mask;
  logic [DW-1:0] p_data, p_out_data;

  coh_mem_bridge #(.SWAP_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
    .fwd_valid_i(fwd_valid_i), .fwd_kind_i(fwd_kind_i), .fwd_addr_i(fwd_addr_i),
    .fwd_instr_i(fwd_instr_i), .fwd_pop_o(fwd_pop_o),
    .wb_valid_i(wb_valid_i), .wb_kind_i(wb_kind_i), .wb_addr_i(wb_addr_i),
    .wb_data_i(wb_data_i), .wb_mask_i(wb_mask_i), .wb_pop_o(wb_pop_o),
    .mem_addr_o(mem_addr_o), .mem_mask_o(mem_mask_o), .mem_data_o(mem_data_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_instr_o(mem_instr_o),
    .mem_avail_o(mem_avail_o), .mem_rd_avail_i(mem_rd_avail_i),
    .mem_wr_avail_i(mem_wr_avail_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_addr_i(mem_rsp_addr_i), .mem_rsp_data_i(mem_rsp_data_i),
    .net_avail_i(net_avail_i), .out_valid_o(out_valid_o),
    .out_addr_o(out_addr_o), .out_data_o(out_data_o));

  coh_mem_bridge #(.SWAP_EN(1'b0)) dut_plain (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
    .fwd_valid_i(fwd_valid_i), .fwd_kind_i(fwd_kind_i), .fwd_addr_i(fwd_addr_i),
    .fwd_instr_i(fwd_instr_i), .fwd_pop_o(p_fwd_pop),
    .wb_valid_i(wb_valid_i), .wb_kind_i(wb_kind_i), .wb_addr_i(wb_addr_i),
    .wb_data_i(wb_data_i), .wb_mask_i(wb_mask_i), .wb_pop_o(p_wb_pop),
    .mem_addr_o(p_addr), .mem_mask_o(p_mask), .mem_data_o(p_data),
    .mem_rd_o(p_rd), .mem_wr_o(p_wr), .mem_instr_o(p_instr),
    .mem_avail_o(p_avail), .mem_rd_avail_i(mem_rd_avail_i),
    .mem_wr_avail_i(mem_wr_avail_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_addr_i(mem_rsp_addr_i), .mem_rsp_data_i(mem_rsp_data_i),
    .net_avail_i(net_avail_i), .out_valid_o(p_out_valid),
    .out_addr_o(p_out_addr), .out_data_o(p_out_data));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    chk(act === exp, tag, DW'(act), DW'(exp));
  endtask

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int w = 0; w < DW/32; w++)
      for (int b = 0; b < 4; b++)
        r[w*32 + b*8 +: 8] = d[w*32 + (3-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input logic [31:0] seed);
    logic [DW-1:0] r;
    for (int w = 0; w < DW/32; w++) r[w*32 +: 32] = seed ^ (32'h01020304 * (w + 1));
    return r;
  endfunction

  task automatic idle;
    enable_i = 1'b1; fwd_valid_i = 1'b0; fwd_kind_i = 2'd3; fwd_addr_i = '0; fwd_instr_i = 1'b0;
    wb_valid_i = 1'b0; wb_kind_i = 2'd3; wb_addr_i = '0; wb_data_i = '0; wb_mask_i = '0;
    mem_rd_avail_i = 1'b1; mem_wr_avail_i = 1'b1; mem_rsp_valid_i = 1'b0;
    mem_rsp_addr_i = '0; mem_rsp_data_i = '0; net_avail_i = 1'b1;
  endtask

  task automatic nxt;
    @(negedge clk);
    #2;
  endtask

  task automatic t_reset;
    chk1(mem_rd_o, 1'b0, "R1 mem_rd_o");
    chk1(mem_wr_o, 1'b0, "R1 mem_wr_o");
    chk1(fwd_pop_o | wb_pop_o, 1'b0, "R1 pops");
    chk1(out_valid_o, 1'b0, "R1 out_valid_o");
    chk1(mem_avail_o, 1'b1, "R1 mem_avail_o");
  endtask

  // read issue, then stall with foreign/matching responses, then write
  task automatic t_read_stall_write;
    logic [DW-1:0] d1, d2, wd;
    d1 = pat(32'hA5A50000); d2 = pat(32'h3C3C1111); wd = pat(32'h77770F0F);
    fwd_valid_i = 1'b1; fwd_kind_i = 2'd0; fwd_addr_i = 32'h0000_1000; fwd_instr_i = 1'b1;
    #2;
    chk1(mem_rd_o, 1'b1, "R2 read issued on shared fetch");
    chk(mem_addr_o == 32'h1000, "R2 read address", DW'(mem_addr_o), DW'(32'h1000));
    chk1(mem_instr_o, 1'b1, "R2 instr flag");
    chk1(fwd_pop_o, 1'b1, "R2 fwd pop");
    nxt;
    fwd_kind_i = 2'd1; fwd_addr_i = 32'h0000_2000; fwd_instr_i = 1'b0;
    wb_valid_i = 1'b1; wb_kind_i = 2'd2; wb_addr_i = 32'h0000_3000; wb_data_i = wd; wb_mask_i = 64'hF0F0_0000_FFFF_0001;
    #1;
    chk1(mem_rd_o | mem_wr_o | fwd_pop_o | wb_pop_o, 1'b0, "R3 stalled while read pending");
    mem_rsp_valid_i = 1'b1; mem_rsp_addr_i = 32'h0000_9000; mem_rsp_data_i = d1;
    nxt;
    mem_rsp_valid_i = 1'b0;
    #1;
    chk1(mem_rd_o | mem_wr_o, 1'b0, "R3 foreign response keeps stall");
    chk1(out_valid_o, 1'b1, "R8 foreign response presented");
    chk(out_addr_o == 32'h9000, "R8 out address", DW'(out_addr_o), DW'(32'h9000));
    chk(out_data_o == flip(d1), "R9 read data swapped", out_data_o, flip(d1));
    chk(p_out_data == d1, "R9 read data plain", p_out_data, d1);
    nxt;
    mem_rsp_valid_i = 1'b1; mem_rsp_addr_i = 32'h0000_1000; mem_rsp_data_i = d2;
    #1;
    chk1(mem_rd_o | mem_wr_o, 1'b0, "R3 still stalled in response cycle");
    nxt;
    mem_rsp_valid_i = 1'b0;
    #1;
    // stall gone; wb holds grant (priority after fwd pop) but buffer not empty
    chk1(out_valid_o, 1'b1, "R8 matching response buffered");
    chk1(mem_wr_o, 1'b0, "R4 write blocked by non-empty buffer");
    chk1(mem_rd_o, 1'b0, "R7 grant held by stalled writeback");
    nxt;
    chk1(mem_wr_o, 1'b1, "R4 write issued");
    chk1(wb_pop_o, 1'b1, "R4 wb pop");
    chk(mem_addr_o == 32'h3000, "R4 write address", DW'(mem_addr_o), DW'(32'h3000));
    chk(mem_mask_o == wb_mask_i, "R4 write mask", DW'(mem_mask_o), DW'(wb_mask_i));
    chk(mem_data_o == flip(wd), "R9 write data swapped", mem_data_o, flip(wd));
    chk(p_data == wd, "R9 write data plain", p_data, wd);
    nxt;
    wb_valid_i = 1'b0;
    #1;
    chk1(mem_rd_o, 1'b1, "R7 fwd served after wb");
    chk(mem_addr_o == 32'h2000, "R2 modified fetch address", DW'(mem_addr_o), DW'(32'h2000));
    chk1(mem_instr_o, 1'b0, "R2 instr flag low");
    nxt;
    fwd_valid_i = 1'b0;
    mem_rsp_valid_i = 1'b1; mem_rsp_addr_i = 32'h0000_2000; mem_rsp_data_i = d1;
    nxt;
    mem_rsp_valid_i = 1'b0;
    nxt; nxt;
  endtask

  task automatic t_guards;
    wb_valid_i = 1'b1; wb_kind_i = 2'd2; wb_addr_i = 32'h40; wb_mask_i = '1;
    mem_wr_avail_i = 1'b0;
    #1;
    chk1(mem_wr_o | wb_pop_o, 1'b0, "R4 blocked by write availability");
    nxt;
    mem_wr_avail_i = 1'b1; net_avail_i = 1'b0;
    #1;
    chk1(mem_wr_o | wb_pop_o, 1'b0, "R4 blocked by network availability");
    nxt;
    net_avail_i = 1'b1; wb_valid_i = 1'b0;
    fwd_valid_i = 1'b1; fwd_kind_i = 2'd0; fwd_addr_i = 32'h80; mem_rd_avail_i = 1'b0;
    #1;
    chk1(mem_rd_o | fwd_pop_o, 1'b0, "R2 blocked by read availability");
    nxt;
    idle;
    nxt;
  endtask

  task automatic t_enable_off;
    enable_i = 1'b0;
    fwd_valid_i = 1'b1; fwd_kind_i = 2'd0; fwd_addr_i = 32'h100;
    wb_valid_i = 1'b1; wb_kind_i = 2'd2;
    #1;
    chk1(mem_rd_o | mem_wr_o | fwd_pop_o | wb_pop_o, 1'b0, "R5 disabled block idle");
    nxt;
    idle;
    nxt;
  endtask

  task automatic t_drop;
    fwd_valid_i = 1'b1; fwd_kind_i = 2'd2;
    #1;
    chk1(fwd_pop_o, 1'b1, "R6 fwd writeback kind dropped");
    chk1(mem_rd_o | mem_wr_o, 1'b0, "R6 no request for fwd drop");
    nxt;
    fwd_valid_i = 1'b0; wb_valid_i = 1'b1; wb_kind_i = 2'd1;
    #1;
    chk1(wb_pop_o, 1'b1, "R6 wb non-writeback dropped");
    chk1(mem_rd_o | mem_wr_o, 1'b0, "R6 no request for wb drop");
    nxt;
    idle;
    nxt;
  endtask

  task automatic t_round_robin;
    logic prev_fwd;
    fwd_valid_i = 1'b1; fwd_kind_i = 2'd3;
    wb_valid_i = 1'b1; wb_kind_i = 2'd2; wb_mask_i = '1;
    #1;
    prev_fwd = fwd_pop_o;
    chk1(fwd_pop_o ^ wb_pop_o, 1'b1, "R7 one queue served");
    for (int i = 0; i < 4; i++) begin
      nxt;
      chk1(fwd_pop_o ^ wb_pop_o, 1'b1, "R7 one queue served");
      chk1(fwd_pop_o, ~prev_fwd, "R7 alternation");
      prev_fwd = fwd_pop_o;
    end
    nxt;
    idle;
    nxt;
  endtask

  task automatic t_fifo_full;
    net_avail_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mem_rsp_valid_i = 1'b1; mem_rsp_addr_i = 32'h500 + 32'(i); mem_rsp_data_i = pat(32'(i));
      #1;
      chk1(mem_avail_o, 1'b1, "R8 space before full");
      nxt;
    end
    mem_rsp_valid_i = 1'b0;
    #1;
    chk1(mem_avail_o, 1'b0, "R8 full deasserts mem_avail_o");
    chk(out_addr_o == 32'h500, "R8 oldest first", DW'(out_addr_o), DW'(32'h500));
    net_avail_i = 1'b1;
    nxt;
    chk1(mem_avail_o, 1'b1, "R8 space after pop");
    chk(out_addr_o == 32'h501, "R8 order", DW'(out_addr_o), DW'(32'h501));
    nxt; nxt; nxt;
    chk1(out_valid_o, 1'b0, "R8 drained");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    t_reset;
    rst_ni = 1'b1;
    nxt;
    t_reset;
    t_read_stall_write;
    t_guards;
    t_enable_off;
    t_drop;
    t_round_robin;
    t_fifo_full;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule